// File: doc/BRIEF.md
# Smart Card Speed Negotiation Sniffer

This block listens, without driving anything, to the bytes that pass over a smart card's I/O line after each card reset. It follows the answer-to-reset: the initial byte, the format byte, the chain of interface bytes and the historical bytes. It then follows the protocol and parameter selection exchange that comes after, first the reader's request and then the card's response. When the card's reply confirms a speed enhancement, the block captures the two multiplier bits and gives one clock-wide pulse. A clock-switching stage downstream uses that pulse to move to the faster bit rate.

Bytes arrive from an upstream serial receiver as a one-cycle strobe with an 8-bit value. The block assumes at least 8 clock cycles between strobes, which holds for any serial byte at practical clock ratios. This spacing lets each optional field that is absent be skipped in a single cycle of its own. Any byte that breaks the expected structure sends the block to a terminal state. It stays there, and asserts the done flag, until the card reset line goes low again.

Top module: `pps_sniffer`

## Requirements
- R1: While `card_rst_n` is sampled low, the block returns to its idle start state with `done`=0, `speed_switch`=0 and `speed_mult`=0, and byte strobes seen during that time are not consumed.
- R2: The first byte after reset must be 8'h3B; any other value makes `done` rise on the following cycle, with no pulse.
- R3: The byte after 8'h3B is the format byte. Its bits 4, 5, 6 and 7 flag the presence of interface bytes A, B, C and D, and its bits 3:0 give the count of historical bytes.
- R4: Interface fields A, B, C and D are visited in that order. A present field consumes one byte, and an absent field is passed over in one clock cycle without consuming a byte.
- R5: A received D byte reloads the presence flags from its bits 7:4 and restarts the walk at field A. If its bits 3:0 are nonzero, a sticky flag is set that adds one check byte at the end of the answer-to-reset.
- R6: After the interface chain, exactly the number of historical bytes given by the format byte is consumed, followed by the check byte only when the sticky flag of R5 is set.
- R7: The byte after the answer-to-reset must be 8'hFF, otherwise `done` rises with no pulse.
- R8: The request byte following 8'hFF has bits 4, 5 and 6 flagging optional parameter bytes 1, 2 and 3. Each present byte is consumed in that order, then one check byte whose value is ignored.
- R9: The response must begin with 8'hFF, and its next byte must have bit 4 set; either violation makes `done` rise with no pulse. Bits 6:4 of that byte become the new presence flags.
- R10: The response parameter byte 1 must have bits 7:2 equal to 6'b100101, otherwise `done` rises with no pulse. On a match its bits 1:0 appear on `speed_mult` on the next cycle and hold until reset.
- R11: The response check byte, received after the optional response bytes 2 and 3, makes `speed_switch` high for exactly one cycle and `done` high from that same cycle onward. Later bytes change neither `done`, `speed_mult` nor `speed_switch`.
- R12: Lowering `card_rst_n` in the middle of an exchange discards all progress; the next byte is again treated as the first byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| card_rst_n | input | 1 | Card reset line, active low, sampled synchronously |
| rx_valid | input | 1 | One-cycle strobe marking a received byte |
| rx_data | input | 8 | Received byte, valid with `rx_valid` |
| speed_switch | output | 1 | One-cycle pulse when the speed enhancement is accepted |
| speed_mult | output | 2 | Accepted speed multiplier bits |
| done | output | 1 | Terminal state reached (success or rejection) |

## Verification
A parser that loses its place in the byte stream, for example by misreading a presence bit or miscounting historical bytes, soon checks the wrong byte for 8'hFF or the response tag. It then shows `done` rising early with no pulse, within one or two byte strobes of the error. A fault in the multiplier latch or in the pulse timing shows as a wrong `speed_mult` value or a pulse that is missing or too wide. That is visible on the cycle after the final check byte. The stimulus uses answer-to-reset streams with no interface bytes, with two chained D bytes, and with and without the sticky check-byte flag. This exposes an off-by-one in any single field as a mismatch at the ports.

// File: rtl/pps_sniff_pkg.sv
// Package: shared widths, protocol constants and the parser state encoding.
// Assumes 8-bit bytes; the nibble and field widths derive from that.
package pps_sniff_pkg;

    localparam int BYTE_W   = 8;
    localparam int NIB_W    = BYTE_W / 2;
    localparam int PRES_W   = 3;   // optional parameter bytes 1..3
    localparam int MULT_W   = 2;
    localparam int TAG_W    = BYTE_W - MULT_W;

    // Bit positions that the walker decodes
    localparam int IF_A     = 0;   // presence nibble index of field A
    localparam int IF_B     = 1;
    localparam int IF_C     = 2;
    localparam int IF_D     = 3;
    localparam int PRES_LSB = 4;   // request/response flag bits start here

    localparam logic [BYTE_W-1:0] INIT_CHAR  = 8'h3B;
    localparam logic [BYTE_W-1:0] SEL_START  = 8'hFF;
    localparam logic [TAG_W-1:0]  RESP_TAG   = 6'b100101;

    typedef enum logic [4:0] {
        S_INIT, S_FMT, S_IFA, S_IFB, S_IFC, S_IFD, S_HIST, S_ACHK,
        S_QSTART, S_Q0, S_Q1, S_Q2, S_Q3, S_QCHK,
        S_ASTART, S_A0, S_A1, S_A2, S_A3, S_ACHK2,
        S_DONE
    } sniff_state_e;

endpackage

// File: rtl/atr_chain_regs.sv
// Module: holds the answer-to-reset walk registers: the presence nibble,
// the historical byte counter and the sticky check-byte flag.
// Assumes the controller never asserts dec_k when the count is zero.
module atr_chain_regs
    import pps_sniff_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_fmt,
    input  logic              load_ifd,
    input  logic              dec_k,
    input  logic [BYTE_W-1:0] byte_in,
    output logic [NIB_W-1:0]  pres,
    output logic              k_zero,
    output logic              chk_flag
);

    logic [NIB_W-1:0] pres_q;
    logic [NIB_W-1:0] k_q;
    logic             chk_q;

    // Purpose: load presence and count, decrement count, set sticky flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pres_q <= '0;
            k_q    <= '0;
            chk_q  <= 1'b0;
        end else begin
            if (load_fmt) begin
                pres_q <= byte_in[BYTE_W-1:NIB_W];
                k_q    <= byte_in[NIB_W-1:0];
            end
            if (load_ifd) begin
                pres_q <= byte_in[BYTE_W-1:NIB_W];
                if (byte_in[NIB_W-1:0] != '0) begin
                    chk_q <= 1'b1;
                end
            end
            if (dec_k) begin
                k_q <= k_q - 1'b1;
            end
        end
    end

    assign pres     = pres_q;
    assign k_zero   = (k_q == '0);
    assign chk_flag = chk_q;

    // R6: the controller only counts down a nonzero historical count
    a_r6_no_count_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        dec_k |-> (k_q != '0));

    // R5: once set, the check-byte flag stays set until reset
    a_r5_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        chk_q |=> chk_q);

endmodule

// File: rtl/sel_field_regs.sv
// Module: holds the selection exchange registers: the three optional-byte
// presence flags and the accepted speed multiplier.
// Assumes loads are single-cycle strobes from the controller.
module sel_field_regs
    import pps_sniff_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_pres,
    input  logic              load_mult,
    input  logic [BYTE_W-1:0] byte_in,
    output logic [PRES_W-1:0] pres,
    output logic [MULT_W-1:0] mult
);

    logic [PRES_W-1:0] pres_q;
    logic [MULT_W-1:0] mult_q;

    // Purpose: capture presence flags and multiplier bits on command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pres_q <= '0;
            mult_q <= '0;
        end else begin
            if (load_pres) begin
                pres_q <= byte_in[PRES_LSB +: PRES_W];
            end
            if (load_mult) begin
                mult_q <= byte_in[MULT_W-1:0];
            end
        end
    end

    assign pres = pres_q;
    assign mult = mult_q;

endmodule

// File: rtl/pps_sniff_fsm.sv
// Module: parser controller. Walks the answer-to-reset and the selection
// request/response, steering the register blocks and raising the
// registered speed-switch pulse.
// Assumes byte strobes are at least 8 cycles apart, so every run of
// skipped absent fields finishes before the next byte.
module pps_sniff_fsm
    import pps_sniff_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic [NIB_W-1:0]  if_pres,
    input  logic              k_zero,
    input  logic              chk_flag,
    input  logic [PRES_W-1:0] sel_pres,
    output sniff_state_e      state,
    output logic              load_fmt,
    output logic              load_ifd,
    output logic              dec_k,
    output logic              load_pres,
    output logic              load_mult,
    output logic              switch_pulse
);

    sniff_state_e state_q, state_d;
    logic         fire;
    logic         pulse_q;

    // Purpose: next-state selection and register-block strobes.
    always_comb begin
        state_d   = state_q;
        load_fmt  = 1'b0;
        load_ifd  = 1'b0;
        dec_k     = 1'b0;
        load_pres = 1'b0;
        load_mult = 1'b0;
        fire      = 1'b0;
        unique case (state_q)
            S_INIT:   if (rx_valid) state_d = (rx_data == INIT_CHAR) ? S_FMT : S_DONE;
            S_FMT:    if (rx_valid) begin
                          load_fmt = 1'b1;
                          state_d  = S_IFA;
                      end
            S_IFA:    if (!if_pres[IF_A] || rx_valid) state_d = S_IFB;
            S_IFB:    if (!if_pres[IF_B] || rx_valid) state_d = S_IFC;
            S_IFC:    if (!if_pres[IF_C] || rx_valid) state_d = S_IFD;
            S_IFD:    if (!if_pres[IF_D]) begin
                          state_d = S_HIST;
                      end else if (rx_valid) begin
                          load_ifd = 1'b1;
                          state_d  = S_IFA;
                      end
            S_HIST:   if (k_zero) begin
                          state_d = S_ACHK;
                      end else if (rx_valid) begin
                          dec_k = 1'b1;
                      end
            S_ACHK:   if (!chk_flag || rx_valid) state_d = S_QSTART;
            S_QSTART: if (rx_valid) state_d = (rx_data == SEL_START) ? S_Q0 : S_DONE;
            S_Q0:     if (rx_valid) begin
                          load_pres = 1'b1;
                          state_d   = S_Q1;
                      end
            S_Q1:     if (!sel_pres[0] || rx_valid) state_d = S_Q2;
            S_Q2:     if (!sel_pres[1] || rx_valid) state_d = S_Q3;
            S_Q3:     if (!sel_pres[2] || rx_valid) state_d = S_QCHK;
            S_QCHK:   if (rx_valid) state_d = S_ASTART;
            S_ASTART: if (rx_valid) state_d = (rx_data == SEL_START) ? S_A0 : S_DONE;
            S_A0:     if (rx_valid) begin
                          if (!rx_data[PRES_LSB]) begin
                              state_d = S_DONE;
                          end else begin
                              load_pres = 1'b1;
                              state_d   = S_A1;
                          end
                      end
            S_A1:     if (rx_valid) begin
                          if (rx_data[BYTE_W-1:MULT_W] == RESP_TAG) begin
                              load_mult = 1'b1;
                              state_d   = S_A2;
                          end else begin
                              state_d = S_DONE;
                          end
                      end
            S_A2:     if (!sel_pres[1] || rx_valid) state_d = S_A3;
            S_A3:     if (!sel_pres[2] || rx_valid) state_d = S_ACHK2;
            S_ACHK2:  if (rx_valid) begin
                          fire    = 1'b1;
                          state_d = S_DONE;
                      end
            S_DONE:   state_d = S_DONE;
            default:  state_d = S_DONE;
        endcase
    end

    // Purpose: state register and registered switch pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_INIT;
            pulse_q <= 1'b0;
        end else begin
            state_q <= state_d;
            pulse_q <= fire;
        end
    end

    assign state        = state_q;
    assign switch_pulse = pulse_q;

    // R1: leaving reset always starts from the idle state
    a_r1_start_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (state_q == S_INIT));

    // R2: a wrong first byte ends the exchange on the next cycle
    a_r2_bad_first: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_INIT && rx_valid && rx_data != INIT_CHAR) |=> (state_q == S_DONE));

    // R4: an absent field A is passed over in one cycle
    a_r4_skip_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IFA && !if_pres[IF_A]) |=> (state_q == S_IFB));

    // R8: an absent request byte 1 is passed over in one cycle
    a_r8_req_skip: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_Q1 && !sel_pres[0]) |=> (state_q == S_Q2));

    // R11: the terminal state is never left before reset
    a_r11_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_DONE) |=> (state_q == S_DONE));

    // R11: the pulse lasts one cycle and coincides with the terminal state
    a_r11_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q |=> !pulse_q);
    a_r11_pulse_in_done: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q |-> (state_q == S_DONE));

endmodule

// File: rtl/pps_sniffer.sv
// Module: top of the speed negotiation sniffer. Connects the controller to
// the answer-to-reset and selection register blocks.
// Assumes a synchronous active-low card reset and byte strobes spaced at
// least 8 clock cycles apart.
module pps_sniffer
    import pps_sniff_pkg::*;
(
    input  logic              clk,
    input  logic              card_rst_n,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    output logic              speed_switch,
    output logic [MULT_W-1:0] speed_mult,
    output logic              done
);

    sniff_state_e      state;
    logic [NIB_W-1:0]  if_pres;
    logic              k_zero;
    logic              chk_flag;
    logic [PRES_W-1:0] sel_pres;
    logic              load_fmt;
    logic              load_ifd;
    logic              dec_k;
    logic              load_pres;
    logic              load_mult;

    pps_sniff_fsm u_fsm (
        .clk          (clk),
        .rst_n        (card_rst_n),
        .rx_valid     (rx_valid),
        .rx_data      (rx_data),
        .if_pres      (if_pres),
        .k_zero       (k_zero),
        .chk_flag     (chk_flag),
        .sel_pres     (sel_pres),
        .state        (state),
        .load_fmt     (load_fmt),
        .load_ifd     (load_ifd),
        .dec_k        (dec_k),
        .load_pres    (load_pres),
        .load_mult    (load_mult),
        .switch_pulse (speed_switch)
    );

    atr_chain_regs u_atr (
        .clk      (clk),
        .rst_n    (card_rst_n),
        .load_fmt (load_fmt),
        .load_ifd (load_ifd),
        .dec_k    (dec_k),
        .byte_in  (rx_data),
        .pres     (if_pres),
        .k_zero   (k_zero),
        .chk_flag (chk_flag)
    );

    sel_field_regs u_sel (
        .clk       (clk),
        .rst_n     (card_rst_n),
        .load_pres (load_pres),
        .load_mult (load_mult),
        .byte_in   (rx_data),
        .pres      (sel_pres),
        .mult      (speed_mult)
    );

    assign done = (state == S_DONE);

    // R10: the multiplier changes only when response byte 1 is taken
    a_r10_mult_hold: assert property (@(posedge clk) disable iff (!card_rst_n)
        (state != S_A1 || !rx_valid) |=> $stable(speed_mult));

    // R11: the switch pulse is never seen outside the terminal state
    a_r11_pulse_done: assert property (@(posedge clk) disable iff (!card_rst_n)
        speed_switch |-> done);

endmodule

// File: tb/pps_sniffer_test.sv
// Bench: walks a table of byte steps with expected port values, then runs
// directed tests for rejection paths and reset behaviour.
module pps_sniffer_test;

    localparam int CLK_PERIOD = 10;
    localparam int GAP        = 8;
    localparam int WDOG       = 20000;

    localparam logic [1:0] OP_RST = 2'd0;  // reset, expect idle outputs
    localparam logic [1:0] OP_MID = 2'd1;  // byte, expect not done, no pulse
    localparam logic [1:0] OP_FIN = 2'd2;  // byte, expect pulse and done
    localparam logic [1:0] OP_END = 2'd3;  // byte, expect done, no pulse

    typedef struct packed {
        logic [1:0] op;
        logic [3:0] req;
        logic [7:0] data;
        logic [1:0] mult;
    } step_t;

    localparam int NV = 52;
    localparam step_t VEC [NV] = '{
        // Case A: bare answer-to-reset, request and response with byte 1 (R3 R4 R8 R10 R11)
        '{OP_RST, 4'd1,  8'h00, 2'd0},
        '{OP_MID, 4'd2,  8'h3B, 2'd0},
        '{OP_MID, 4'd3,  8'h00, 2'd0},
        '{OP_MID, 4'd7,  8'hFF, 2'd0},
        '{OP_MID, 4'd8,  8'h10, 2'd0},
        '{OP_MID, 4'd8,  8'h94, 2'd0},
        '{OP_MID, 4'd8,  8'h5A, 2'd0},
        '{OP_MID, 4'd9,  8'hFF, 2'd0},
        '{OP_MID, 4'd9,  8'h10, 2'd0},
        '{OP_MID, 4'd10, 8'h96, 2'd2},
        '{OP_FIN, 4'd11, 8'h33, 2'd2},
        '{OP_END, 4'd11, 8'h3B, 2'd2},
        // Case B: all four fields, two D bytes, sticky flag, history, all options (R5 R6)
        '{OP_RST, 4'd1,  8'h00, 2'd0},
        '{OP_MID, 4'd2,  8'h3B, 2'd0},
        '{OP_MID, 4'd3,  8'hF2, 2'd0},
        '{OP_MID, 4'd4,  8'h11, 2'd0},
        '{OP_MID, 4'd4,  8'h00, 2'd0},
        '{OP_MID, 4'd4,  8'h00, 2'd0},
        '{OP_MID, 4'd5,  8'h81, 2'd0},
        '{OP_MID, 4'd5,  8'h31, 2'd0},
        '{OP_MID, 4'd4,  8'h96, 2'd0},
        '{OP_MID, 4'd4,  8'h00, 2'd0},
        '{OP_MID, 4'd6,  8'h41, 2'd0},
        '{OP_MID, 4'd6,  8'h42, 2'd0},
        '{OP_MID, 4'd6,  8'h5C, 2'd0},
        '{OP_MID, 4'd7,  8'hFF, 2'd0},
        '{OP_MID, 4'd8,  8'h71, 2'd0},
        '{OP_MID, 4'd8,  8'h97, 2'd0},
        '{OP_MID, 4'd8,  8'h00, 2'd0},
        '{OP_MID, 4'd8,  8'h00, 2'd0},
        '{OP_MID, 4'd8,  8'hEE, 2'd0},
        '{OP_MID, 4'd9,  8'hFF, 2'd0},
        '{OP_MID, 4'd9,  8'h71, 2'd0},
        '{OP_MID, 4'd10, 8'h97, 2'd3},
        '{OP_MID, 4'd11, 8'h00, 2'd3},
        '{OP_MID, 4'd11, 8'h00, 2'd3},
        '{OP_FIN, 4'd11, 8'hEE, 2'd3},
        // Case C: D byte with zero low nibble, request without byte 1 (R5 R8)
        '{OP_RST, 4'd1,  8'h00, 2'd0},
        '{OP_MID, 4'd2,  8'h3B, 2'd0},
        '{OP_MID, 4'd3,  8'h80, 2'd0},
        '{OP_MID, 4'd5,  8'h00, 2'd0},
        '{OP_MID, 4'd7,  8'hFF, 2'd0},
        '{OP_MID, 4'd8,  8'h60, 2'd0},
        '{OP_MID, 4'd8,  8'h00, 2'd0},
        '{OP_MID, 4'd8,  8'h00, 2'd0},
        '{OP_MID, 4'd8,  8'h60, 2'd0},
        '{OP_MID, 4'd9,  8'hFF, 2'd0},
        '{OP_MID, 4'd9,  8'h10, 2'd0},
        '{OP_MID, 4'd10, 8'h95, 2'd1},
        '{OP_FIN, 4'd11, 8'h84, 2'd1},
        // Case D: wrong first byte (R2)
        '{OP_RST, 4'd1,  8'h00, 2'd0},
        '{OP_END, 4'd2,  8'h3F, 2'd0}
    };

    logic       clk;
    logic       card_rst_n;
    logic       rx_valid;
    logic [7:0] rx_data;
    logic       speed_switch;
    logic [1:0] speed_mult;
    logic       done;

    int n_checks;
    int n_fails;
    bit finished;

    pps_sniffer uut (
        .clk          (clk),
        .card_rst_n   (card_rst_n),
        .rx_valid     (rx_valid),
        .rx_data      (rx_data),
        .speed_switch (speed_switch),
        .speed_mult   (speed_mult),
        .done         (done)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input int req, input string what,
                         input logic [3:0] act, input logic [3:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL R%0d %s: actual {sw,done,mult}=%b expected %b", req, what, act, exp);
        end
    endtask

    task automatic do_reset(input int req);
        @(negedge clk);
        card_rst_n = 1'b0;
        repeat (2) @(negedge clk);
        card_rst_n = 1'b1;
        check(req, "reset state", {speed_switch, done, speed_mult}, 4'b0000);
        repeat (2) @(negedge clk);
    endtask

    task automatic step(input logic [1:0] op, input int req,
                        input logic [7:0] b, input logic [1:0] m);
        logic [3:0] exp;
        if (op == OP_RST) begin
            do_reset(req);
        end else begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_data  = b;
            @(negedge clk);
            rx_valid = 1'b0;
            rx_data  = 8'h00;
            case (op)
                OP_MID:  exp = {1'b0, 1'b0, m};
                OP_FIN:  exp = {1'b1, 1'b1, m};
                default: exp = {1'b0, 1'b1, m};
            endcase
            check(req, $sformatf("after byte %h", b), {speed_switch, done, speed_mult}, exp);
            @(negedge clk);
            if (op == OP_FIN) begin
                // R11: pulse is gone one cycle later, done and multiplier hold
                check(req, "pulse width", {speed_switch, done, speed_mult}, {1'b0, 1'b1, m});
            end
            repeat (GAP - 2) @(negedge clk);
        end
    endtask

    initial begin
        card_rst_n = 1'b0;
        rx_valid   = 1'b0;
        rx_data    = 8'h00;
        n_checks   = 0;
        n_fails    = 0;
        finished   = 1'b0;
        repeat (3) @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            step(VEC[i].op, int'(VEC[i].req), VEC[i].data, VEC[i].mult);
        end

        // R7: byte after the answer-to-reset is not 8'hFF
        step(OP_RST, 1, 8'h00, 2'd0);
        step(OP_MID, 2, 8'h3B, 2'd0);
        step(OP_MID, 3, 8'h00, 2'd0);
        step(OP_END, 7, 8'h00, 2'd0);

        // R9: response byte 0 lacks the byte-1 flag
        step(OP_RST, 1, 8'h00, 2'd0);
        step(OP_MID, 2, 8'h3B, 2'd0);
        step(OP_MID, 3, 8'h00, 2'd0);
        step(OP_MID, 7, 8'hFF, 2'd0);
        step(OP_MID, 8, 8'h00, 2'd0);
        step(OP_MID, 8, 8'hAA, 2'd0);
        step(OP_MID, 9, 8'hFF, 2'd0);
        step(OP_END, 9, 8'h20, 2'd0);

        // R9: response does not start with 8'hFF
        step(OP_RST, 1, 8'h00, 2'd0);
        step(OP_MID, 2, 8'h3B, 2'd0);
        step(OP_MID, 3, 8'h00, 2'd0);
        step(OP_MID, 7, 8'hFF, 2'd0);
        step(OP_MID, 8, 8'h00, 2'd0);
        step(OP_MID, 8, 8'hAA, 2'd0);
        step(OP_END, 9, 8'hFE, 2'd0);

        // R10: response byte 1 upper bits mismatch, multiplier untouched
        step(OP_RST, 1, 8'h00, 2'd0);
        step(OP_MID, 2, 8'h3B, 2'd0);
        step(OP_MID, 3, 8'h00, 2'd0);
        step(OP_MID, 7, 8'hFF, 2'd0);
        step(OP_MID, 8, 8'h10, 2'd0);
        step(OP_MID, 8, 8'h94, 2'd0);
        step(OP_MID, 8, 8'h84, 2'd0);
        step(OP_MID, 9, 8'hFF, 2'd0);
        step(OP_MID, 9, 8'h10, 2'd0);
        step(OP_END, 10, 8'h13, 2'd0);

        // R12: reset mid-stream, next byte is treated as the first again
        step(OP_RST, 1, 8'h00, 2'd0);
        step(OP_MID, 2, 8'h3B, 2'd0);
        step(OP_MID, 3, 8'hF0, 2'd0);
        step(OP_RST, 12, 8'h00, 2'd0);
        step(OP_END, 12, 8'h00, 2'd0);

        // R1: strobes during reset are not consumed
        @(negedge clk);
        card_rst_n = 1'b0;
        rx_valid   = 1'b1;
        rx_data    = 8'h3B;
        @(negedge clk);
        rx_valid   = 1'b0;
        @(negedge clk);
        check(1, "held in reset", {speed_switch, done, speed_mult}, 4'b0000);
        card_rst_n = 1'b1;
        repeat (2) @(negedge clk);
        step(OP_END, 1, 8'h00, 2'd0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (WDOG) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual run still busy, expected end within %0d cycles", WDOG);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule